// File: doc/BRIEF.md
# Temperature-Aware DRAM Refresh Scheduler

This block tells a DRAM command sequencer when an auto-refresh is due. A free-running timer counts controller clocks against a programmable interval. Each time the interval expires, one refresh is added to a backlog. The request output stays high while the backlog is non-zero. Each acknowledge from the sequencer removes one entry. When more than eight refreshes are owed, an urgent flag tells the sequencer to serve refresh ahead of all other traffic. Tracking postponed refreshes this way keeps the full refresh count per retention window. For example, 8192 refreshes in 64 ms means one every 7.8 µs, which is 3120 clocks at 400 MHz.

A high-temperature flag halves the interval, giving 3.9 µs (1560 clocks at 400 MHz). The new length is taken only when the current interval ends, so an interval in progress is never cut short. While the self-refresh control is high, the DRAM refreshes itself. During that time the block clears its backlog, holds its timer and raises no request. When self refresh ends, the timer starts again from zero and one refresh is requested at once.

Top module: `refresh_scheduler`

## Requirements
- R1: During and right after a synchronous active-high reset, `ref_req` and `ref_urgent` are 0 and `ref_backlog` is 0.
- R2: With `temp_hot` low, an interval lasts `cfg_interval` clocks. After the reset is released, `ref_backlog` rises by one on every `cfg_interval`-th rising edge, provided there is no acknowledge.
- R3: With `temp_hot` high, an interval lasts `cfg_interval >> 1` clocks. An effective length of 0 is treated as 1.
- R4: The interval length (from `temp_hot` and `cfg_interval`) is sampled only at reset, at the end of an interval, and on leaving self refresh. A change on these inputs in mid-interval does not shorten or stretch the interval already running.
- R5: `ref_req` is 1 exactly when `ref_backlog` is non-zero. It stays high until enough acknowledges have arrived. Each cycle with `ref_ack` high and a non-zero backlog lowers the backlog by one.
- R6: Refreshes that expire without an acknowledge accumulate in `ref_backlog`. If an interval expires in the same cycle as an accepted acknowledge, the backlog is unchanged.
- R7: `ref_urgent` is 1 exactly when `ref_backlog` is greater than 8.
- R8: `ref_backlog` saturates at 15 and does not wrap.
- R9: A cycle with `self_refresh` high clears the backlog, so `ref_req` and `ref_urgent` are 0 after that edge. While `self_refresh` stays high, `ref_ack` has no effect and the timer does not advance.
- R10: On the first edge where `self_refresh` is low after being high, `ref_backlog` becomes 1 and `ref_req` rises. The next refresh then falls due one full interval after that edge.
- R11: An acknowledge while the backlog is 0 is ignored; the backlog never underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_interval | input | CNT_W | Clocks per interval in the normal temperature range |
| temp_hot | input | 1 | High-temperature flag; halves the interval |
| self_refresh | input | 1 | High while the DRAM is in self refresh |
| ref_req | output | 1 | Refresh request to the command sequencer |
| ref_urgent | output | 1 | Backlog above the postpone limit |
| ref_ack | input | 1 | One refresh issued by the sequencer |
| ref_backlog | output | DEBT_W | Number of refreshes owed |

## Verification
The hardest states to reach from the ports are the ones at the top of the backlog: crossing the urgent threshold and hitting saturation, and then draining back under the threshold while intervals keep expiring. The bench uses a two-clock interval and withholds acknowledges to fill the backlog quickly. It then holds the acknowledge high, so that expiry and acknowledge coincide on every other edge, and compares the result with an arithmetic count. A temperature flip in mid-interval and a self-refresh exit on a chosen edge cover the boundary-only switch and the timer restart.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  // Effective interval length: halved in the hot range, never below one clock.
  function automatic logic [31:0] eff_period(input logic [31:0] base, input logic hot);
    logic [31:0] p;
    p = hot ? (base >> 1) : base;
    if (p == 32'd0) p = 32'd1;
    return p;
  endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [CNT_W-1:0] cfg_interval,
  input  logic             temp_hot,
  output logic             tick
);
  import refresh_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period_r;
  logic [CNT_W-1:0] next_period;
  logic [31:0]      calc;
  logic             at_end;

  always_comb begin
    calc        = eff_period(32'(cfg_interval), temp_hot);
    next_period = calc[CNT_W-1:0];
  end

  assign at_end = (cnt == period_r - 1'b1);
  assign tick   = !rst && !hold && at_end;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt      <= '0;
      period_r <= next_period;
    end else if (at_end) begin
      cnt      <= '0;
      period_r <= next_period;
    end else begin
      cnt      <= cnt + 1'b1;
    end
  end

  // R4
  period_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !at_end) |=> (period_r == $past(period_r)));

  // R9
  timer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt == '0));

endmodule

// File: rtl/refresh_debt_tracker.sv
module refresh_debt_tracker #(
  parameter int DEBT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ack,
  input  logic              clr,
  input  logic              seed,
  output logic [DEBT_W-1:0] debt,
  output logic [DEBT_W-1:0] debt_nxt
);
  localparam logic [DEBT_W-1:0] DEBT_MAX = '1;

  logic take;
  assign take = ack && (debt != '0);

  always_comb begin
    debt_nxt = debt;
    if (rst || clr) begin
      debt_nxt = '0;
    end else if (seed) begin
      debt_nxt = {{(DEBT_W-1){1'b0}}, 1'b1};
    end else begin
      unique case ({tick, take})
        2'b10:   debt_nxt = (debt == DEBT_MAX) ? debt : debt + 1'b1;
        2'b01:   debt_nxt = debt - 1'b1;
        default: debt_nxt = debt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    debt <= debt_nxt;
  end

  // R8
  debt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (debt == DEBT_MAX && tick && !ack && !clr && !seed) |=> (debt == DEBT_MAX));

  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (debt == '0 && !tick && !clr && !seed) |=> (debt == '0));

  // R6
  tick_ack_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && take && !clr && !seed) |=> $stable(debt));

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler #(
  parameter int CNT_W        = 16,
  parameter int DEBT_W       = 4,
  parameter int POSTPONE_MAX = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cfg_interval,
  input  logic              temp_hot,
  input  logic              self_refresh,
  output logic              ref_req,
  output logic              ref_urgent,
  input  logic              ref_ack,
  output logic [DEBT_W-1:0] ref_backlog
);
  localparam logic [DEBT_W-1:0] URGENT_LVL = DEBT_W'(POSTPONE_MAX);

  logic              sr_q;
  logic              sr_exit;
  logic              tick;
  logic [DEBT_W-1:0] debt_nxt;

  always_ff @(posedge clk) begin
    sr_q <= self_refresh;
  end

  assign sr_exit = sr_q && !self_refresh;

  refresh_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .hold         (self_refresh || sr_exit),
    .cfg_interval (cfg_interval),
    .temp_hot     (temp_hot),
    .tick         (tick)
  );

  refresh_debt_tracker #(.DEBT_W(DEBT_W)) u_debt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .ack      (ref_ack),
    .clr      (self_refresh),
    .seed     (sr_exit),
    .debt     (ref_backlog),
    .debt_nxt (debt_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_req    <= 1'b0;
      ref_urgent <= 1'b0;
    end else begin
      ref_req    <= (debt_nxt != '0);
      ref_urgent <= (debt_nxt > URGENT_LVL);
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_ack && !self_refresh) |=> ref_req);

  // R7
  urgent_level_chk: assert property (@(posedge clk) disable iff (rst)
    ref_urgent |-> (ref_backlog > URGENT_LVL));

  // R9
  sr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    self_refresh |=> (!ref_req && !ref_urgent));

  // R10
  sr_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(self_refresh) |=> (ref_req && ref_backlog == 1));

endmodule

// File: tb/sim_refresh_scheduler.sv
module sim_refresh_scheduler;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int DEBT_W = 4;

  logic clk = 0;
  logic rst = 1;
  logic [CNT_W-1:0] cfg_interval = 16'd8;
  logic temp_hot = 0;
  logic self_refresh = 0;
  logic ref_ack = 0;
  logic ref_req, ref_urgent;
  logic [DEBT_W-1:0] ref_backlog;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_scheduler u0 (
    .clk(clk), .rst(rst), .cfg_interval(cfg_interval), .temp_hot(temp_hot),
    .self_refresh(self_refresh), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .ref_ack(ref_ack), .ref_backlog(ref_backlog)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic outs(string tag, int exp_backlog);
    chk({tag, " backlog"}, int'(ref_backlog), exp_backlog);
    chk({tag, " req"}, int'(ref_req), int'(exp_backlog != 0));
    chk({tag, " urgent"}, int'(ref_urgent), int'(exp_backlog > 8));
  endtask

  task automatic do_reset(int c, bit h);
    @(negedge clk);
    cfg_interval = CNT_W'(c);
    temp_hot = h;
    self_refresh = 0;
    ref_ack = 0;
    rst = 1;
    repeat (2) @(negedge clk);
    outs("R1 in reset", 0);
    rst = 0;
  endtask

  function automatic int per(int c, bit h);
    int p;
    p = h ? (c >> 1) : c;
    return (p == 0) ? 1 : p;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2 / R3: sweep interval and temperature range
    for (int c = 1; c <= 11; c++) begin
      for (int h = 0; h < 2; h++) begin
        int p;
        p = per(c, h[0]);
        do_reset(c, h[0]);
        for (int k = 1; k <= 3 * p; k++) begin
          @(negedge clk);
          outs(h[0] ? "R3 hot interval" : "R2 normal interval", k / p);
        end
      end
    end

    // R4: temperature change takes effect only at the boundary
    do_reset(10, 0);
    repeat (4) @(negedge clk);
    temp_hot = 1;
    repeat (5) @(negedge clk);
    outs("R4 edge9", 0);
    @(negedge clk);
    outs("R4 edge10", 1);
    repeat (4) @(negedge clk);
    outs("R4 edge14", 1);
    @(negedge clk);
    outs("R4 edge15", 2);
    repeat (2) @(negedge clk);
    temp_hot = 0;
    repeat (3) @(negedge clk);
    outs("R4 edge20", 3);
    repeat (9) @(negedge clk);
    outs("R4 edge29", 3);
    @(negedge clk);
    outs("R4 edge30", 4);

    // R5 / R6 / R11: hold, acknowledge, coincidence, ack at zero
    do_reset(6, 0);
    repeat (6) @(negedge clk);
    outs("R5 first due", 1);
    repeat (5) @(negedge clk);
    outs("R5 held without ack edge11", 1);
    ref_ack = 1;
    @(negedge clk);
    outs("R6 tick and ack edge12", 1);
    @(negedge clk);
    outs("R5 ack lowers edge13", 0);
    repeat (4) @(negedge clk);
    outs("R11 ack at zero edge17", 0);
    @(negedge clk);
    outs("R11 tick with ack at zero edge18", 1);
    ref_ack = 0;
    repeat (6) @(negedge clk);
    outs("R6 accumulate edge24", 2);

    // R7 / R8: fill to saturation, then drain with ack held
    do_reset(2, 0);
    for (int k = 1; k <= 40; k++) begin
      int e;
      @(negedge clk);
      e = (k / 2 > 15) ? 15 : k / 2;
      outs(k > 30 ? "R8 saturate" : "R7 urgent fill", e);
    end
    begin
      int exp_b;
      exp_b = 15;
      ref_ack = 1;
      for (int k = 41; k <= 60; k++) begin
        bit t;
        @(negedge clk);
        t = (k % 2 == 0);
        if (!t && exp_b > 0) exp_b--;
        outs("R7 urgent drain", exp_b);
      end
      ref_ack = 0;
    end

    // R9 / R10: self refresh entry, quiet period, exit
    do_reset(8, 0);
    repeat (8) @(negedge clk);
    outs("R10 before entry", 1);
    self_refresh = 1;
    @(negedge clk);
    outs("R9 entry clears", 0);
    for (int k = 10; k <= 29; k++) begin
      ref_ack = k[0];
      @(negedge clk);
      outs("R9 quiet", 0);
    end
    ref_ack = 0;
    self_refresh = 0;
    @(negedge clk);
    outs("R10 exit request", 1);
    repeat (7) @(negedge clk);
    outs("R10 edge37", 1);
    @(negedge clk);
    outs("R10 restart edge38", 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule